// File: doc/BRIEF.md
# Conditional Data-Processing Unit

This block performs one 32-bit data-processing operation per clock and decides whether that operation may take effect. It receives a 4-bit operation code, a flag-save request, a first operand, an already shifted second operand, the carry bit produced by the shifter, the current N/Z/C/V flags and a 4-bit condition selector. It returns the operation result, a write enable for the destination register, the next flag values and a condition-pass indication.

Sixteen operations are supported. They include bitwise operations, add and subtract with and without carry-in, reverse subtract forms that swap the operands, and four compare/test forms that only affect flags. Bitwise operations take their carry flag from the shifter. Arithmetic operations produce carry and overflow from the adder. A 16-entry condition predicate over the incoming flags gates every effect: on a failed condition nothing is written and the flags are unchanged.

All four outputs are registered once, so they appear one clock after the inputs are presented. The register file, the shifter and instruction fetch sit outside the block.

Top module: `alu_flag_core`

## Requirements
- R1: Operation codes: 0 A&B, 1 A^B, 2 A-B, 3 B-A, 4 A+B, 5 A+B+C, 6 A+~B+C, 7 B+~A+C, 8 A&B (test), 9 A^B (test), 10 A-B (test), 11 A+B (test), 12 A|B, 13 B, 14 A&~B, 15 ~B. The result output always carries the value of the operation, whether or not it is written.
- R2: A subtraction is formed as X + ~Y + carry-in. The carry-in is 1 for codes 2, 3 and 10, and the current C flag for codes 6 and 7. Codes 3 and 7 take B as X and A as Y.
- R3: For arithmetic codes (2 to 7, 10, 11) with save set and the condition passing, N is result bit 31, Z is 1 when the result is zero, C is the carry out of bit 31, and V is 1 when both adder inputs have the same sign and the result's sign differs from it.
- R4: For bitwise codes (0, 1, 8, 9, 12 to 15) with save set and the condition passing, N and Z come from the result, C takes the shifter carry input, and V keeps its incoming value.
- R5: Codes 8 to 11 never assert the write enable. With save set they update the flags as in R3/R4. With save clear they have no effect at all.
- R6: The flags port is packed as {N,Z,C,V}, bits 3 to 0. The condition passes for: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R7: When the condition fails, the write enable is low and the flags output equals the flags input.
- R8: With save clear, the flags output equals the flags input for every code.
- R9: Every output is registered, so it reflects the inputs sampled at the previous rising edge. Asynchronous active-low reset clears all outputs to zero.
- R10: The write enable is high exactly when the condition passes and the code is outside 8 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| save_i | input | 1 | Request to update the flags |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Carry out of the shifter |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| cond_i | input | 4 | Condition selector |
| res_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| pass_o | output | 1 | Condition passed |

## Verification
The only state is the single output register, so a wrong internal decision shows at the ports one clock after the stimulus. An error in the condition predicate or in the operation decode appears as a wrong write enable, a wrong pass bit or a changed flag on that next cycle. A wrong carry-in choice or operand swap appears as a result that differs by one or is negated. The bench therefore sweeps every code against operands at the sign and zero boundaries, and every condition against all sixteen flag combinations.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    function automatic logic op_is_test(input logic [3:0] op);
        return (op >= 4'd8) && (op <= 4'd11);
    endfunction

    function automatic logic op_is_arith(input logic [3:0] op);
        return ((op >= 4'd2) && (op <= 4'd7)) || (op == 4'd10) || (op == 4'd11);
    endfunction

endpackage

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_pkg::*;
(
    input  logic [3:0] flags_i,
    input  logic [3:0] cond_i,
    output logic       pass_o
);
    logic n, z, c, v;

    always_comb begin
        n = flags_i[FLAG_N];
        z = flags_i[FLAG_Z];
        c = flags_i[FLAG_C];
        v = flags_i[FLAG_V];
        unique case (cond_i)
            4'd0:    pass_o = z;
            4'd1:    pass_o = !z;
            4'd2:    pass_o = c;
            4'd3:    pass_o = !c;
            4'd4:    pass_o = n;
            4'd5:    pass_o = !n;
            4'd6:    pass_o = v;
            4'd7:    pass_o = !v;
            4'd8:    pass_o = c && !z;
            4'd9:    pass_o = !c || z;
            4'd10:   pass_o = (n == v);
            4'd11:   pass_o = (n != v);
            4'd12:   pass_o = !z && (n == v);
            4'd13:   pass_o = z || (n != v);
            4'd14:   pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o
);
    localparam int SW = W + 1;

    logic [W-1:0]  x, y;
    logic          ci;
    logic [SW-1:0] sum;

    always_comb begin
        unique case (op_i)
            OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; ci = 1'b1;  end
            OP_RSB:         begin x = b_i; y = ~a_i; ci = 1'b1;  end
            OP_ADC:         begin x = a_i; y = b_i;  ci = cin_i; end
            OP_SBC:         begin x = a_i; y = ~b_i; ci = cin_i; end
            OP_RSC:         begin x = b_i; y = ~a_i; ci = cin_i; end
            default:        begin x = a_i; y = b_i;  ci = 1'b0;  end
        endcase
        sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        res_o = sum[W-1:0];
        c_o   = sum[W];
        v_o   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [3:0]   op_i,
    input  logic         save_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         shc_i,
    input  logic [3:0]   flags_i,
    input  logic [3:0]   cond_i,
    output logic [W-1:0] res_o,
    output logic         wr_en_o,
    output logic [3:0]   flags_o,
    output logic         pass_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         wr_en;
        logic [3:0]   flags;
        logic         pass;
    } out_s;

    out_s state_d, state_q;

    logic         pass_c;
    logic [W-1:0] logic_res;
    logic [W-1:0] arith_res;
    logic         arith_c, arith_v;

    alu_cond_eval u_cond (
        .flags_i (flags_i),
        .cond_i  (cond_i),
        .pass_o  (pass_c)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (logic_res)
    );

    alu_arith_unit #(.W(W)) u_arith (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (flags_i[FLAG_C]),
        .res_o (arith_res),
        .c_o   (arith_c),
        .v_o   (arith_v)
    );

    always_comb begin
        logic arith;
        arith         = op_is_arith(op_i);
        state_d.pass  = pass_c;
        state_d.res   = arith ? arith_res : logic_res;
        state_d.wr_en = pass_c && !op_is_test(op_i);
        state_d.flags = flags_i;
        if (pass_c && save_i) begin
            state_d.flags[FLAG_N] = state_d.res[W-1];
            state_d.flags[FLAG_Z] = (state_d.res == '0);
            if (arith) begin
                state_d.flags[FLAG_C] = arith_c;
                state_d.flags[FLAG_V] = arith_v;
            end else begin
                state_d.flags[FLAG_C] = shc_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign res_o   = state_q.res;
    assign wr_en_o = state_q.wr_en;
    assign flags_o = state_q.flags;
    assign pass_o  = state_q.pass;
endmodule

// File: rtl/alu_flag_core_chk.sv
module alu_flag_core_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [3:0]   op_i,
    input logic         save_i,
    input logic [3:0]   flags_i,
    input logic [3:0]   cond_i,
    input logic [W-1:0] res_o,
    input logic         wr_en_o,
    input logic [3:0]   flags_o,
    input logic         pass_o
);
    // R10: no write without a passing condition
    p_write_needs_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> pass_o);

    // R5: compare/test codes never write
    p_test_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(op_i) >= 4'd8 && $past(op_i) <= 4'd11) |-> !wr_en_o);

    // R8: save clear keeps flags
    p_nosave_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(save_i)) |-> (flags_o == $past(flags_i)));

    // R7: failed condition keeps flags and blocks the write
    p_fail_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !pass_o) |-> (!wr_en_o && flags_o == $past(flags_i)));

    // R6: selector 14 always passes, 15 never does
    p_always_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(cond_i) == 4'd14) |-> pass_o);
    p_never_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(cond_i) == 4'd15) |-> !pass_o);

    // R4: bitwise codes keep V
    p_logic_keeps_v_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ($past(op_i) <= 4'd1 || $past(op_i) == 4'd8 ||
          $past(op_i) == 4'd9 || $past(op_i) >= 4'd12))
        |-> (flags_o[0] == $past(flags_i[0])));

    // R3/R4: Z agrees with the registered result whenever flags were saved
    p_z_matches_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(save_i) && pass_o) |-> (flags_o[2] == (res_o == '0)));
endmodule

bind alu_flag_core alu_flag_core_chk #(.W(W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op_i),
    .save_i  (save_i),
    .flags_i (flags_i),
    .cond_i  (cond_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .flags_o (flags_o),
    .pass_o  (pass_o)
);

// File: tb/sim_alu_flag_core.sv
`timescale 1ns/1ps
module sim_alu_flag_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic        save = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        shc = 1'b0;
    logic [3:0]  fl = '0;
    logic [3:0]  cond = 4'd14;
    logic [31:0] res;
    logic        we, ps;
    logic [3:0]  fo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu_flag_core u0 (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .save_i(save), .a_i(a), .b_i(b),
        .shc_i(shc), .flags_i(fl), .cond_i(cond), .res_o(res), .wr_en_o(we),
        .flags_o(fo), .pass_o(ps)
    );

    logic [31:0] bnd [4] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && n == v;
            13: return z || n != v;
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model(input logic [3:0] o, input logic s, input logic [31:0] x,
                         input logic [31:0] y, input logic sc, input logic [3:0] f,
                         input logic [3:0] c, output logic [31:0] r, output logic w,
                         output logic [3:0] nf, output logic p);
        logic [32:0] t;
        logic [31:0] p1, p2;
        logic        ari;
        ari = 1'b1;
        p1 = x; p2 = y;
        case (o)
            2, 10: begin p1 = x; p2 = ~y; t = {1'b0, x} + {1'b0, ~y} + 33'd1; end
            3:     begin p1 = y; p2 = ~x; t = {1'b0, y} + {1'b0, ~x} + 33'd1; end
            4, 11: t = {1'b0, x} + {1'b0, y};
            5:     t = {1'b0, x} + {1'b0, y} + {32'd0, f[1]};
            6:     begin p1 = x; p2 = ~y; t = {1'b0, x} + {1'b0, ~y} + {32'd0, f[1]}; end
            7:     begin p1 = y; p2 = ~x; t = {1'b0, y} + {1'b0, ~x} + {32'd0, f[1]}; end
            default: begin
                ari = 1'b0;
                case (o)
                    0, 8: t = {1'b0, x & y};
                    1, 9: t = {1'b0, x ^ y};
                    12:   t = {1'b0, x | y};
                    13:   t = {1'b0, y};
                    14:   t = {1'b0, x & ~y};
                    default: t = {1'b0, ~y};
                endcase
            end
        endcase
        r  = t[31:0];
        p  = cond_ok(c, f);
        w  = p && !(o >= 8 && o <= 11);
        nf = f;
        if (p && s) begin
            nf[3] = r[31];
            nf[2] = (r == 0);
            if (ari) begin
                nf[1] = t[32];
                nf[0] = (p1[31] == p2[31]) && (r[31] != p1[31]);
            end else nf[1] = sc;
        end
    endtask

    task automatic chk(input string tag, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d cond=%0d save=%0b: got res=%h we=%b fl=%b ps=%b, expected res=%h we=%b fl=%b ps=%b",
                     tag, op, cond, save, act[37:6], act[5], act[4:1], act[0],
                     exp[37:6], exp[5], exp[4:1], exp[0]);
        end
    endtask

    task automatic vec(input string tag, input logic [3:0] o, input logic s,
                       input logic [31:0] x, input logic [31:0] y, input logic sc,
                       input logic [3:0] f, input logic [3:0] c);
        logic [31:0] r; logic w, p; logic [3:0] nf;
        @(negedge clk);
        op = o; save = s; a = x; b = y; shc = sc; fl = f; cond = c;
        model(o, s, x, y, sc, f, c, r, w, nf, p);
        @(negedge clk);
        chk(tag, {res, we, fo, ps}, {r, w, nf, p});
    endtask

    // R9: reset state and one-cycle latency
    task automatic t_reset_latency();
        #1;
        chk("R9 reset", {res, we, fo, ps}, 38'd0);
        @(negedge clk); rst_n = 1'b1;
        op = 4'd4; save = 1'b0; a = 32'd5; b = 32'd7; cond = 4'd14; fl = 4'b0000;
        #1;
        chk("R9 before edge", {res, we, fo, ps}, 38'd0);
        @(negedge clk);
        chk("R9 after edge", {res, we, fo, ps}, {32'd12, 1'b1, 4'b0000, 1'b1});
    endtask

    // R1 R2 R3 R4 R8 R10: every code at the boundary values and at random values
    task automatic t_all_ops();
        for (int o = 0; o < 16; o++)
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        vec(s ? "R1/R3/R4 boundary" : "R1/R8 boundary",
                            o[3:0], s[0], bnd[i], bnd[j], j[0], {i[1:0], j[1:0]}, 4'd14);
                for (int k = 0; k < 8; k++)
                    vec(s ? "R2/R3/R4 random" : "R2/R8 random", o[3:0], s[0],
                        $urandom, $urandom, k[0], 4'($urandom), 4'd14);
            end
    endtask

    // R6: every condition against every flag combination
    task automatic t_conditions();
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                vec("R6 condition", 4'd4, 1'b1, 32'h1234, 32'h10, 1'b0, f[3:0], c[3:0]);
    endtask

    // R7: failing condition keeps flags and blocks the write
    task automatic t_cond_fail();
        vec("R7 never", 4'd2, 1'b1, 32'd0, 32'd1, 1'b1, 4'b1010, 4'd15);
        vec("R7 EQ with Z clear", 4'd13, 1'b1, 32'd0, 32'd0, 1'b1, 4'b0001, 4'd0);
        vec("R7 GT failing", 4'd15, 1'b1, 32'd0, 32'd0, 1'b0, 4'b1000, 4'd12);
    endtask

    // R5: compare/test codes with and without save
    task automatic t_test_ops();
        vec("R5 CMP equal", 4'd10, 1'b1, 32'd9, 32'd9, 1'b0, 4'b0000, 4'd14);
        vec("R5 CMN wrap", 4'd11, 1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0, 4'b0000, 4'd14);
        vec("R5 TST no save", 4'd8, 1'b0, 32'hF0, 32'h0F, 1'b1, 4'b1111, 4'd14);
        vec("R5 TEQ no save", 4'd9, 1'b0, 32'h5, 32'h5, 1'b0, 4'b0110, 4'd14);
    endtask

    // R2: carry-in selection and operand swap, directed values
    task automatic t_carry_forms();
        vec("R2 SBC C=0", 4'd6, 1'b1, 32'd10, 32'd3, 1'b0, 4'b0000, 4'd14);
        vec("R2 SBC C=1", 4'd6, 1'b1, 32'd10, 32'd3, 1'b0, 4'b0010, 4'd14);
        vec("R2 RSB", 4'd3, 1'b1, 32'd3, 32'd10, 1'b0, 4'b0000, 4'd14);
        vec("R2 RSC C=0", 4'd7, 1'b1, 32'd3, 32'd10, 1'b0, 4'b0000, 4'd14);
        vec("R3 ADD overflow", 4'd4, 1'b1, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'b0000, 4'd14);
    endtask

    initial begin
        t_reset_latency();
        t_all_ops();
        t_conditions();
        t_cond_fail();
        t_test_ops();
        t_carry_forms();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #900_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule